// File: doc/BRIEF.md
# SCSI Block-Move Transfer Engine

This block carries out one block-move command on the initiator side of a parallel SCSI bus. A command gives a 32-bit word, which holds the expected bus phase and a byte count, and a start address. The engine waits for the target to raise REQ. On that first REQ it captures the bus phase lines and compares them with the phase in the command. If the two agree, it moves the requested number of bytes through asynchronous REQ/ACK handshakes. Bytes flow between the bus and a simple byte-wide memory port. If the two differ, it raises a one-cycle interrupt and moves nothing.

Two phases need special bus handling. A Message-Out move that follows an ATN request drops ATN during its final handshake. A Message-In move leaves ACK asserted after its last byte until the controller issues a clear-ACK command. When the controller is acting as a target, a command does not handshake at all. It drives the commanded phase onto the bus phase lines.

Top module: `scsi_move_engine`

## Requirements
- R1: On `start` in idle, the commanded phase is taken from `cmd_word[26:24]` and the byte count from `cmd_word[23:0]`. Bits [31:27] have no effect.
- R2: REQ and the phase lines pass through two synchronizing flops. `latched_phase` takes the synchronized phase, encoded {MSG,C/D,I/O}, on every synchronized rising edge of REQ.
- R3: When the phases match, exactly `count` bytes move at addresses `cmd_addr`, `cmd_addr+1` and so on. In input phases (I/O=1: 001 Data-In, 011 Status, 111 Message-In), each byte on `bus_din` is written to memory. In output phases (000 Data-Out, 010 Command, 110 Message-Out), `bus_dout` shows the memory byte with `bus_dout_oe` high.
- R4: A mismatch on the first REQ pulses `mismatch_irq` for one cycle and returns to idle, with no ACK and no memory write. The reserved codes 100 and 101 always mismatch.
- R5: ACK rises only after REQ is seen high. It falls only after REQ is seen low, or on a clear-ACK command. It is still high on the cycle after the target releases REQ.
- R6: When a move ends, `done` pulses for one cycle, `busy` goes low and `count_left` reads zero. After reset the engine is idle with ACK, ATN and all output enables low.
- R7: A byte count of zero completes with `done` and no phase check, handshake or interrupt.
- R8: `set_atn` raises ATN. The first Message-Out move completed after that drops ATN in the same cycle that ACK rises for its last byte, and ATN stays high on its earlier bytes. Moves in other phases leave ATN unchanged.
- R9: For a Message-In move, ACK stays high after the last byte until `clr_ack` arrives. `clr_ack` has no effect on an ACK that is not being held.
- R10: With `target_mode` high, a start drives the commanded phase on `bus_phase_out` with `bus_phase_oe` high, then completes with no comparison and no handshake. The next initiator start releases the phase lines.
- R11: A `start` while a move is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (one-cycle pulse) |
| cmd_word | input | 32 | Phase in [26:24], byte count in [23:0] |
| cmd_addr | input | ADDR_W | First memory address |
| target_mode | input | 1 | Act as target: drive phase only |
| set_atn | input | 1 | Assert ATN and arm its release |
| clr_ack | input | 1 | Release a held ACK |
| bus_req | input | 1 | REQ from the target (asynchronous) |
| bus_phase_in | input | 3 | {MSG,C/D,I/O} from the target |
| bus_din | input | 8 | Bus data into the engine |
| bus_dout | output | 8 | Bus data out of the engine |
| bus_dout_oe | output | 1 | Output enable for `bus_dout` |
| bus_ack | output | 1 | ACK to the target |
| bus_atn | output | 1 | ATN to the target |
| bus_phase_out | output | 3 | Phase driven in target mode |
| bus_phase_oe | output | 1 | Enable for `bus_phase_out` |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (combinational) |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch_irq | output | 1 | One-cycle phase-mismatch pulse |
| latched_phase | output | 3 | Phase captured on the last REQ rise |
| count_left | output | 24 | Bytes remaining |

## Verification
A wrong address or count register shows at the memory port and on `count_left`. The engine writes a byte at the wrong address, writes one byte too many or too few, or reports a non-zero count when it finishes. A wrong first-byte flag or a bad comparison shows within three clocks of the first REQ, as an ACK where an interrupt belongs or the reverse. A wrong ATN arming bit shows on the ATN line at the final ACK of a Message-Out move. A wrong ACK-hold bit shows on the cycles after the last Message-In byte, when ACK either drops too early or never answers `clr_ack`.

// File: rtl/scsi_move_engine.sv
module scsi_move_engine #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cmd_word,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              target_mode,
  input  logic              set_atn,
  input  logic              clr_ack,
  input  logic              bus_req,
  input  logic [2:0]        bus_phase_in,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic              bus_dout_oe,
  output logic              bus_ack,
  output logic              bus_atn,
  output logic [2:0]        bus_phase_out,
  output logic              bus_phase_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              mismatch_irq,
  output logic [2:0]        latched_phase,
  output logic [23:0]       count_left
);
  localparam int PH_LSB = 24;
  localparam int CNT_W  = PH_LSB;
  localparam logic [2:0] PH_MSG_OUT = 3'b110;
  localparam logic [2:0] PH_MSG_IN  = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_REQ, S_WAIT_DROP} state_t;

  state_t            state;
  logic [1:0]        req_sync;
  logic              req_d;
  logic [2:0]        ph_s1, ph_s2;
  logic [2:0]        phase_q, latch_q, tgt_ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              first_q, ack_q, hold_q, atn_q, armed_q;
  logic              done_q, irq_q, tgt_oe_q;
  logic [4:0]        unused_cmd_bits;

  wire              req_s    = req_sync[1];
  wire              req_rise = req_s & ~req_d;
  wire [2:0]        cmd_ph   = cmd_word[PH_LSB+2:PH_LSB];
  wire [CNT_W-1:0]  cmd_cnt  = cmd_word[CNT_W-1:0];
  wire              last     = (cnt_q == CNT_W'(1));
  wire              phase_ok = (ph_s2 == phase_q) && (phase_q[2:1] != 2'b10);
  wire              xfer_ok  = !first_q || phase_ok;

  assign unused_cmd_bits = cmd_word[31:PH_LSB+3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      req_d    <= 1'b0;
      ph_s1    <= '0;
      ph_s2    <= '0;
    end else begin
      req_sync <= {req_sync[0], bus_req};
      req_d    <= req_s;
      ph_s1    <= bus_phase_in;
      ph_s2    <= ph_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase_q  <= '0;
      latch_q  <= '0;
      tgt_ph_q <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      first_q  <= 1'b0;
      ack_q    <= 1'b0;
      hold_q   <= 1'b0;
      atn_q    <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      tgt_oe_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      if (req_rise) latch_q <= ph_s2;
      if (set_atn) begin
        atn_q   <= 1'b1;
        armed_q <= 1'b1;
      end
      if (clr_ack && hold_q) begin
        ack_q  <= 1'b0;
        hold_q <= 1'b0;
      end
      case (state)
        S_IDLE: if (start) begin
          phase_q <= cmd_ph;
          addr_q  <= cmd_addr;
          first_q <= 1'b1;
          if (target_mode) begin
            tgt_ph_q <= cmd_ph;
            tgt_oe_q <= 1'b1;
            cnt_q    <= '0;
            done_q   <= 1'b1;
          end else begin
            tgt_oe_q <= 1'b0;
            cnt_q    <= cmd_cnt;
            if (cmd_cnt == '0) done_q <= 1'b1;
            else               state  <= S_WAIT_REQ;
          end
        end
        S_WAIT_REQ: if (req_rise) begin
          if (!xfer_ok) begin
            irq_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            first_q <= 1'b0;
            ack_q   <= 1'b1;
            hold_q  <= 1'b0;
            if (last && phase_q == PH_MSG_OUT && armed_q) begin
              atn_q   <= 1'b0;
              armed_q <= 1'b0;
            end
            state <= S_WAIT_DROP;
          end
        end
        S_WAIT_DROP: if (!req_s) begin
          if (last && phase_q == PH_MSG_IN) hold_q <= 1'b1;
          else                              ack_q  <= 1'b0;
          cnt_q  <= cnt_q - CNT_W'(1);
          addr_q <= addr_q + ADDR_W'(1);
          if (last) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_WAIT_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign done          = done_q;
  assign mismatch_irq  = irq_q;
  assign latched_phase = latch_q;
  assign count_left    = cnt_q;
  assign bus_ack       = ack_q;
  assign bus_atn       = atn_q;
  assign bus_phase_out = tgt_ph_q;
  assign bus_phase_oe  = tgt_oe_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = bus_din;
  assign mem_we        = (state == S_WAIT_REQ) && req_rise && phase_q[0] && xfer_ok;
  assign bus_dout      = mem_rdata;
  assign bus_dout_oe   = busy && !phase_q[0];

  assert_ack_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> req_s);
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> (!req_s || $past(clr_ack)));
  assert_no_write_on_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_irq |-> !$past(mem_we));
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_irq |=> !mismatch_irq);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && count_left == '0));
  assert_atn_drop_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_atn) |-> $rose(bus_ack));
  assert_no_phase_drive_in_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bus_phase_oe);
  assert_write_only_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !bus_dout_oe));
endmodule

// File: tb/sim_scsi_move_engine.sv
module sim_scsi_move_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] cmd_addr = '0;
  logic        target_mode = 1'b0;
  logic        set_atn = 1'b0;
  logic        clr_ack = 1'b0;
  logic        bus_req = 1'b0;
  logic [2:0]  bus_phase_in = '0;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_dout_oe, bus_ack, bus_atn, bus_phase_oe;
  logic [2:0]  bus_phase_out, latched_phase;
  logic [31:0] mem_addr;
  logic        mem_we, busy, done, mismatch_irq;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [23:0] count_left;

  logic [7:0]  mem [0:255];
  logic        atn_log [0:15];
  int          n_checks = 0, n_fail = 0;
  int          irq_cnt = 0, done_cnt = 0, wr_cnt = 0, acks_seen = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  scsi_move_engine #(.ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word), .cmd_addr(cmd_addr),
    .target_mode(target_mode), .set_atn(set_atn), .clr_ack(clr_ack),
    .bus_req(bus_req), .bus_phase_in(bus_phase_in), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_ack(bus_ack), .bus_atn(bus_atn),
    .bus_phase_out(bus_phase_out), .bus_phase_oe(bus_phase_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .mismatch_irq(mismatch_irq),
    .latched_phase(latched_phase), .count_left(count_left));

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  always @(negedge clk) begin
    if (mismatch_irq) irq_cnt++;
    if (done) done_cnt++;
    if (mem_we) wr_cnt++;
  end

  typedef struct packed {
    logic [2:0] cph;
    logic [2:0] bph;
    logic [7:0] n;
    logic [7:0] base;
    logic       mism;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'b001, 3'b001, 8'd5, 8'h10, 1'b0},
    '{3'b000, 3'b000, 8'd4, 8'h40, 1'b0},
    '{3'b010, 3'b010, 8'd6, 8'h60, 1'b0},
    '{3'b011, 3'b011, 8'd1, 8'h80, 1'b0},
    '{3'b001, 3'b000, 8'd3, 8'h90, 1'b1},
    '{3'b100, 3'b100, 8'd2, 8'h98, 1'b1},
    '{3'b000, 3'b011, 8'd2, 8'h9C, 1'b1}
  };

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return base ^ 8'(i * 3 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] ph, input logic [23:0] n, input logic [7:0] base, input bit tm);
    @(negedge clk);
    target_mode = tm;
    cmd_word = {5'b10110, ph, n};
    cmd_addr = {24'h0, base};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic prep(input logic [7:0] base, input int n);
    for (int i = 0; i <= n; i++) mem[8'(base + 8'(i))] = (i < n) ? pat(base, i) : 8'h00;
  endtask

  task automatic clear(input logic [7:0] base, input int n);
    for (int i = 0; i <= n; i++) mem[8'(base + 8'(i))] = 8'h00;
  endtask

  task automatic serve(input logic [2:0] ph, input int n, input logic [7:0] seed, input logic [7:0] base);
    int t;
    bus_phase_in = ph;
    acks_seen = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (ph[0]) bus_din = seed + 8'(i);
      check(!bus_ack, "R5", "ACK low before REQ", bus_ack, 0);
      bus_req = 1'b1;
      t = 0;
      while (!bus_ack && t < 40) begin @(negedge clk); t++; end
      check(bus_ack, "R5", "ACK answers REQ", bus_ack, 1);
      if (!bus_ack) begin bus_req = 1'b0; return; end
      acks_seen++;
      atn_log[i] = bus_atn;
      if (!ph[0])
        check(bus_dout_oe && bus_dout == pat(base, i), "R3", "output byte on bus",
              bus_dout, pat(base, i));
      bus_req = 1'b0;
      @(negedge clk);
      check(bus_ack, "R5", "ACK held until REQ release is seen", bus_ack, 1);
      if (i == n - 1 && ph == 3'b111) begin
        repeat (4) @(negedge clk);
      end else begin
        t = 0;
        while (bus_ack && t < 40) begin @(negedge clk); t++; end
        check(!bus_ack, "R5", "ACK released after REQ low", bus_ack, 0);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int d0, i0, w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !bus_ack && !bus_atn && !bus_phase_oe && !bus_dout_oe && count_left == 0,
          "R6", "reset idle state", {busy, bus_ack, bus_atn, bus_phase_oe, bus_dout_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t x;
      x = VECS[v];
      if (x.cph[0]) clear(x.base, int'(x.n)); else prep(x.base, int'(x.n));
      d0 = done_cnt; i0 = irq_cnt; w0 = wr_cnt;
      go(x.cph, {16'h0, x.n}, x.base, 1'b0);
      check(busy, "R1", "busy after start", busy, 1);
      if (x.mism) begin
        bus_phase_in = x.bph;
        repeat (3) @(negedge clk);
        bus_req = 1'b1;
        repeat (8) @(negedge clk);
        check(!bus_ack, "R4", "no ACK on mismatch", bus_ack, 0);
        check(irq_cnt - i0 == 1, "R4", "mismatch interrupt count", irq_cnt - i0, 1);
        check(wr_cnt == w0, "R4", "no memory writes", wr_cnt - w0, 0);
        check(!busy && done_cnt == d0, "R4", "idle without done", done_cnt - d0, 0);
        check(latched_phase == x.bph, "R2", "latched phase", latched_phase, x.bph);
        bus_req = 1'b0;
        repeat (4) @(negedge clk);
      end else begin
        serve(x.bph, int'(x.n), 8'h21 + 8'(v), x.base);
        check(acks_seen == int'(x.n), "R3", "handshake count", acks_seen, x.n);
        check(latched_phase == x.bph, "R2", "latched phase", latched_phase, x.bph);
        check(done_cnt - d0 == 1 && !busy && count_left == 0, "R6", "done pulse and zero count",
              done_cnt - d0, 1);
        check(irq_cnt == i0, "R3", "no interrupt on match", irq_cnt - i0, 0);
        if (x.cph[0]) begin
          for (int i = 0; i < int'(x.n); i++)
            check(mem[8'(x.base + 8'(i))] == 8'(8'h21 + 8'(v) + 8'(i)), "R3", "byte stored in order",
                  mem[8'(x.base + 8'(i))], 8'(8'h21 + 8'(v) + 8'(i)));
          check(mem[8'(x.base + x.n)] == 8'h00, "R3", "no write past count",
                mem[8'(x.base + x.n)], 0);
        end else begin
          check(wr_cnt == w0, "R3", "no writes in output phase", wr_cnt - w0, 0);
        end
      end
    end

    d0 = done_cnt; i0 = irq_cnt;
    bus_phase_in = 3'b101;
    go(3'b001, 24'd0, 8'hB0, 1'b0);
    repeat (3) @(negedge clk);
    check(done_cnt - d0 == 1 && !busy && !bus_ack && irq_cnt == i0, "R7", "zero count completes at once",
          done_cnt - d0, 1);

    @(negedge clk); set_atn = 1'b1; @(negedge clk); set_atn = 1'b0;
    check(bus_atn, "R8", "ATN raised by set", bus_atn, 1);
    prep(8'hA0, 3);
    go(3'b110, 24'd3, 8'hA0, 1'b0);
    serve(3'b110, 3, 8'h00, 8'hA0);
    check(atn_log[0] && atn_log[1], "R8", "ATN high on early bytes", {atn_log[0], atn_log[1]}, 3);
    check(!atn_log[2] && !bus_atn, "R8", "ATN low at last ACK", atn_log[2], 0);

    @(negedge clk); set_atn = 1'b1; @(negedge clk); set_atn = 1'b0;
    prep(8'hA8, 2);
    go(3'b000, 24'd2, 8'hA8, 1'b0);
    serve(3'b000, 2, 8'h00, 8'hA8);
    check(atn_log[0] && atn_log[1] && bus_atn, "R8", "ATN kept through Data-Out move",
          {atn_log[0], atn_log[1], bus_atn}, 7);
    prep(8'hAC, 1);
    go(3'b110, 24'd1, 8'hAC, 1'b0);
    serve(3'b110, 1, 8'h00, 8'hAC);
    check(!atn_log[0] && !bus_atn, "R8", "single-byte Message-Out drops ATN", atn_log[0], 0);

    clear(8'hB8, 1);
    go(3'b001, 24'd1, 8'hB8, 1'b0);
    bus_phase_in = 3'b001; bus_din = 8'h5D;
    repeat (3) @(negedge clk);
    bus_req = 1'b1;
    repeat (5) @(negedge clk);
    clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
    repeat (2) @(negedge clk);
    check(bus_ack, "R9", "clear-ACK ignored when not held", bus_ack, 1);
    bus_req = 1'b0;
    repeat (5) @(negedge clk);
    check(!bus_ack && mem[8'hB8] == 8'h5D, "R9", "normal release after clear ignored", bus_ack, 0);

    clear(8'hC0, 3);
    d0 = done_cnt;
    go(3'b111, 24'd3, 8'hC0, 1'b0);
    serve(3'b111, 3, 8'h31, 8'hC0);
    check(bus_ack, "R9", "ACK held after last Message-In byte", bus_ack, 1);
    check(done_cnt - d0 == 1 && !busy, "R9", "Message-In move completed", done_cnt - d0, 1);
    check(mem[8'hC2] == 8'h33, "R3", "Message-In last byte stored", mem[8'hC2], 8'h33);
    repeat (3) @(negedge clk);
    check(bus_ack, "R9", "ACK still held", bus_ack, 1);
    clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
    @(negedge clk);
    check(!bus_ack, "R9", "ACK released by clear", bus_ack, 0);

    d0 = done_cnt; i0 = irq_cnt;
    bus_phase_in = 3'b000;
    go(3'b011, 24'd5, 8'hD0, 1'b1);
    repeat (2) @(negedge clk);
    check(bus_phase_oe && bus_phase_out == 3'b011, "R10", "target drives phase", bus_phase_out, 3'b011);
    check(done_cnt - d0 == 1 && !busy && !bus_ack && irq_cnt == i0 && count_left == 0,
          "R10", "target command completes without handshake", done_cnt - d0, 1);
    go(3'b000, 24'd0, 8'hD0, 1'b0);
    @(negedge clk);
    check(!bus_phase_oe, "R10", "initiator start releases phase lines", bus_phase_oe, 0);

    clear(8'hE0, 2); clear(8'hF0, 2);
    d0 = done_cnt;
    go(3'b001, 24'd2, 8'hE0, 1'b0);
    go(3'b011, 24'd4, 8'hF0, 1'b0);
    serve(3'b001, 2, 8'h71, 8'hE0);
    check(mem[8'hE0] == 8'h71 && mem[8'hE1] == 8'h72 && mem[8'hF0] == 8'h00, "R11",
          "second start ignored", {mem[8'hE0], mem[8'hE1], mem[8'hF0]}, 24'h717200);
    check(done_cnt - d0 == 1 && !busy, "R11", "one completion only", done_cnt - d0, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule